// File: doc/BRIEF.md
# Central PCI Bus Arbiter with Internal Parking

This block decides which of several bus initiators may use a shared PCI bus. Each initiator raises its active-low request line; the arbiter answers with at most one active-low grant. It watches the shared FRAME#, IRDY# and STOP# lines to learn when a transaction starts, when it ends and when a target has asked for a retry. A grant is taken away at the end of each transaction, and one fully idle clock always separates the removal of one grant from the issue of the next.

When nobody is requesting and the bus is idle, the grant is parked on one fixed internal initiator, and a drive-enable output tells that initiator to hold the address/data, command/byte-enable and parity lines at valid levels. External initiators are never parked on. A retry ends the retried master's grant at once, so another pending initiator is served next and a device whose master and target halves are coupled can make progress. Selection among simultaneous requesters is round-robin by request index.

Top module: `pci_grant_arbiter`

## Requirements
- R1: At most one bit of `gnt_n` is low in any cycle, including when several requests arrive together; during reset all of `gnt_n` is high and `park_drive_en` is low.
- R2: Requesters are served round-robin: after master k has been granted, the search for the next grant starts at index k+1 and wraps; the first search after reset starts at index 0.
- R3: A grant is only issued in the cycle after one in which the bus was idle (`frame_n` and `irdy_n` both high); while the bus is busy no new grant appears.
- R4: Whenever a grant is removed, `gnt_n` is all high for at least one clock before any grant is asserted again.
- R5: With the bus idle and no request pending, the grant goes one clock later to master `PARK_IDX` (which must be marked internal in `INTERNAL_MASK`) and `park_drive_en` rises in that same clock; `park_drive_en` is high only while parked.
- R6: A granted master that has started a transaction keeps its grant until the clock after the bus is seen idle, then loses it; a master other than `PARK_IDX` is never left granted with no request.
- R7: If `stop_n` is low while a transaction is in progress, the grant is removed at the next clock even if the master still requests, and the next grant follows the normal round-robin order among pending requests.
- R8: A granted master that does not pull `frame_n` low holds its grant for exactly `GRANT_TIMEOUT` clocks (16 by default) and then loses it.
- R9: A granted master that withdraws its request before starting a transaction loses its grant at the next clock.
- R10: While parked, `frame_n` going low makes the transaction belong to the parked master, and its grant is kept until the bus is idle again even if another master requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N_MASTERS | Active-low request, one per initiator |
| frame_n | input | 1 | Shared FRAME#, active low |
| irdy_n | input | 1 | Shared IRDY#, active low |
| stop_n | input | 1 | Shared STOP#, active low; taken as a target retry/disconnect |
| gnt_n | output | N_MASTERS | Active-low grant, at most one low |
| park_drive_en | output | 1 | High while parked: parked master must drive AD, C/BE# and PAR |

## Verification
The bench builds the arbiter with its defaults: four initiators, masters 0 and 1 internal and 2 and 3 external, parking on master 0 and a 16-clock start timeout. Four requesters make the round-robin wrap visible and allow two simultaneous requests to be resolved across the wrap point, while the external indices let the bench confirm that grants to them are dropped after a transaction and after a retry. Keeping the timeout at 16 lets the bench count the exact hold length of an unused grant in a few dozen clocks.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

   // Arbiter phases
   typedef enum logic [1:0] {
      ARB_GAP  = 2'd0,  // no grant driven, waiting for an idle bus
      ARB_OFFER = 2'd1, // grant given, waiting for FRAME#
      ARB_BUSY = 2'd2,  // transaction in progress
      ARB_PARK = 2'd3   // parked on the internal default master
   } arb_state_e;

endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
   parameter int N_REQ = 4,
   localparam int IW   = $clog2(N_REQ)
) (
   input  logic [N_REQ-1:0] req,
   input  logic [IW-1:0]    last,
   output logic             any,
   output logic [IW-1:0]    pick
);

   // Search starts one past the last winner and wraps around.
   always_comb begin
      any  = 1'b0;
      pick = last;
      for (int k = 1; k <= N_REQ; k++) begin
         if (!any && req[(int'(last) + k) % N_REQ]) begin
            any  = 1'b1;
            pick = IW'((int'(last) + k) % N_REQ);
         end
      end
   end

   // R2
   always_comb begin
      pick_valid_chk : assert (!any || req[pick]);
   end

endmodule

// File: rtl/offer_timer.sv
module offer_timer #(
   parameter int LIMIT = 16,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   logic [CW-1:0] cnt;

   assign expired = (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pci_grant_arbiter.sv
module pci_grant_arbiter
   import pci_arb_pkg::*;
#(
   parameter int                   N_MASTERS     = 4,
   parameter logic [N_MASTERS-1:0] INTERNAL_MASK = 4'b0011,
   parameter int                   PARK_IDX      = 0,
   parameter int                   GRANT_TIMEOUT = 16,
   localparam int                  IW            = $clog2(N_MASTERS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_n,
   input  logic                 frame_n,
   input  logic                 irdy_n,
   input  logic                 stop_n,
   output logic [N_MASTERS-1:0] gnt_n,
   output logic                 park_drive_en
);

   // Elaboration-time parameter checks
   if (N_MASTERS < 2) begin : g_bad_count
      $error("pci_grant_arbiter: N_MASTERS must be at least 2");
   end
   if (PARK_IDX < 0 || PARK_IDX >= N_MASTERS) begin : g_bad_park
      $error("pci_grant_arbiter: PARK_IDX out of range");
   end else if (!INTERNAL_MASK[PARK_IDX]) begin : g_park_ext
      $error("pci_grant_arbiter: parking master must be internal");
   end
   if (GRANT_TIMEOUT < 2) begin : g_bad_tmo
      $error("pci_grant_arbiter: GRANT_TIMEOUT must be at least 2");
   end

   localparam logic [IW-1:0]        PARK_ID  = IW'(PARK_IDX);
   localparam logic [N_MASTERS-1:0] PARK_BIT = N_MASTERS'(1) << PARK_IDX;

   arb_state_e           state;
   logic [IW-1:0]        owner;
   logic [IW-1:0]        last_win;
   logic [N_MASTERS-1:0] req;
   logic [N_MASTERS-1:0] gnt_vec;
   logic                 bus_idle;
   logic                 pick_any;
   logic [IW-1:0]        pick_idx;
   logic                 tmo_expired;

   assign req      = ~req_n;
   assign bus_idle = frame_n && irdy_n;

   rr_picker #(.N_REQ(N_MASTERS)) u_pick (
      .req  (req),
      .last (last_win),
      .any  (pick_any),
      .pick (pick_idx)
   );

   offer_timer #(.LIMIT(GRANT_TIMEOUT)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ARB_OFFER),
      .expired (tmo_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ARB_GAP;
         owner    <= PARK_ID;
         last_win <= IW'(N_MASTERS - 1);
      end else begin
         unique case (state)
            ARB_GAP: begin
               if (bus_idle) begin
                  if (pick_any) begin
                     owner    <= pick_idx;
                     last_win <= pick_idx;
                     state    <= ARB_OFFER;
                  end else begin
                     owner <= PARK_ID;
                     state <= ARB_PARK;
                  end
               end
            end
            ARB_OFFER: begin
               if (!frame_n)                        state <= ARB_BUSY;
               else if (!req[owner] || tmo_expired) state <= ARB_GAP;
            end
            ARB_BUSY: begin
               if (!stop_n || bus_idle) state <= ARB_GAP;
            end
            ARB_PARK: begin
               if (!frame_n)                   state <= ARB_BUSY;
               else if (|(req & ~PARK_BIT))    state <= ARB_GAP;
            end
            default: state <= ARB_GAP;
         endcase
      end
   end

   // One grant line per master, decoded from the owner index
   for (genvar i = 0; i < N_MASTERS; i++) begin : g_gnt
      assign gnt_vec[i] = (state != ARB_GAP) && (owner == IW'(i));
   end

   assign gnt_n         = ~gnt_vec;
   assign park_drive_en = (state == ARB_PARK);

   // R1
   one_grant_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_vec));

   // R4
   gap_between_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vec != '0) |=> (gnt_vec == '0) || (gnt_vec == $past(gnt_vec)));

   // R3
   grant_on_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|gnt_vec) |-> $past(frame_n && irdy_n));

   // R5
   park_drive_chk : assert property (@(posedge clk) disable iff (!rst_n)
      park_drive_en |-> (gnt_vec == PARK_BIT));

   // R7
   retry_drop_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ARB_BUSY && !stop_n) |=> (gnt_vec == '0));

   // R8
   start_timeout_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ARB_OFFER && tmo_expired && frame_n) |=> (gnt_vec == '0));

endmodule

// File: tb/pci_grant_arbiter_tb.sv
module pci_grant_arbiter_tb;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] req_n;
   logic         frame_n, irdy_n, stop_n;
   logic [N-1:0] gnt_n;
   logic         park_drive_en;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   pci_grant_arbiter u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_n         (req_n),
      .frame_n       (frame_n),
      .irdy_n        (irdy_n),
      .stop_n        (stop_n),
      .gnt_n         (gnt_n),
      .park_drive_en (park_drive_en)
   );

   localparam logic [N-1:0] NONE = 4'b1111;

   function automatic logic [N-1:0] g(input int idx);
      return ~(N'(1) << idx);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // Owner idx is granted at this negedge; run a two-phase transaction.
   task automatic do_xfer(input int idx, input string tag);
      frame_n = 1'b0; irdy_n = 1'b0;
      step();
      chk({tag, " hold in data phase (R6)"}, gnt_n, g(idx));
      frame_n = 1'b1; req_n[idx] = 1'b1;
      step();
      chk({tag, " hold in last phase (R6)"}, gnt_n, g(idx));
      irdy_n = 1'b1;
      step();
      chk({tag, " released after idle (R6, R4)"}, gnt_n, NONE);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; req_n = NONE; frame_n = 1'b1; irdy_n = 1'b1; stop_n = 1'b1;
      repeat (3) step();
      chk("reset grants (R1)", gnt_n, NONE);
      chk("reset park enable (R1)", park_drive_en, 0);
      rst_n = 1'b1;
      step();
      chk("park after reset (R5)", gnt_n, g(0));
      chk("park enable after reset (R5)", park_drive_en, 1);
   endtask

   task automatic t_external();
      req_n[2] = 1'b0;
      step();
      chk("gap leaving park (R4)", gnt_n, NONE);
      chk("park enable drops (R5)", park_drive_en, 0);
      step();
      chk("first rr grant from index 0 (R2)", gnt_n, g(2));
      do_xfer(2, "ext2");
      chk("ext2 no park enable in gap (R5)", park_drive_en, 0);
      step();
      chk("park not on external (R6, R5)", gnt_n, g(0));
      chk("park enable one clock later (R5)", park_drive_en, 1);
   endtask

   task automatic t_coincident();
      req_n[1] = 1'b0; req_n[3] = 1'b0;
      step();
      chk("gap before coincident grant (R4)", gnt_n, NONE);
      step();
      chk("coincident: single grant to 3 (R1, R2)", gnt_n, g(3));
      do_xfer(3, "m3");
      step();
      chk("rr wraps to 1 (R2)", gnt_n, g(1));
      do_xfer(1, "m1");
      step();
      chk("park after coincident (R5)", gnt_n, g(0));
   endtask

   task automatic t_retry();
      req_n[2] = 1'b0; req_n[3] = 1'b0;
      step();
      step();
      chk("retry setup grant 2 (R2)", gnt_n, g(2));
      frame_n = 1'b0; irdy_n = 1'b0;
      step();
      stop_n = 1'b0;
      step();
      chk("grant dropped on STOP# (R7)", gnt_n, NONE);
      frame_n = 1'b1;
      step();
      chk("no grant while IRDY# low (R3)", gnt_n, NONE);
      irdy_n = 1'b1; stop_n = 1'b1;
      step();
      chk("re-arbitration picks 3 (R7)", gnt_n, g(3));
      do_xfer(3, "m3 after retry");
      step();
      chk("retried master 2 served again (R7)", gnt_n, g(2));
      do_xfer(2, "m2 retry done");
      step();
      chk("park after retry test (R5)", gnt_n, g(0));
   endtask

   task automatic t_park_use();
      frame_n = 1'b0; irdy_n = 1'b0; req_n[1] = 1'b0;
      step();
      chk("parked master owns transaction (R10)", gnt_n, g(0));
      chk("drive enable off in transfer (R5)", park_drive_en, 0);
      step();
      chk("no grant to 1 while busy (R3, R10)", gnt_n, g(0));
      frame_n = 1'b1;
      step();
      chk("still no grant to 1 (R3)", gnt_n, g(0));
      irdy_n = 1'b1;
      step();
      chk("gap after parked transfer (R4)", gnt_n, NONE);
      step();
      chk("grant 1 after idle (R2, R3)", gnt_n, g(1));
      req_n[1] = 1'b1;
      step();
      chk("withdrawn request loses grant (R9)", gnt_n, NONE);
      step();
      chk("park after withdrawal (R5)", gnt_n, g(0));
   endtask

   task automatic t_timeout();
      int cnt = 0;
      req_n[3] = 1'b0;
      step();
      step();
      chk("timeout setup grant 3 (R2)", gnt_n, g(3));
      while (gnt_n[3] == 1'b0 && cnt < 40) begin
         cnt++;
         step();
      end
      chk("unused grant held 16 clocks (R8)", cnt, 16);
      chk("grant gone after timeout (R8, R4)", gnt_n, NONE);
      req_n[3] = 1'b1;
      step();
      chk("park after timeout (R5)", gnt_n, g(0));
      chk("park enable after timeout (R5)", park_drive_en, 1);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      t_reset();
      t_external();
      t_coincident();
      t_retry();
      t_park_use();
      t_timeout();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

endmodule